// File: doc/BRIEF.md
# Entropy Sample Health Gate and 256-bit Packer

This block sits between a free-running random bit source and a downstream conditioner. Raw bits arrive one at a time on a valid/ready stream. The source runs asynchronously and has already been brought into the core clock, so bits arrive at irregular intervals. The block groups the accepted bits into 256-bit samples and judges each sample on the fly. A sample is judged on two things: its count of ones, and the longest stretch of identical bits inside it. The block then writes the packed word, tagged healthy or unhealthy, into a four-entry queue. The conditioner pops words from that queue through a second valid/ready stream.

Back-pressure works in both directions through the queue's fill state. The input is ready only while the queue has a free entry and the self test has passed. Words at the output stay stable until they are popped. After every reset the block first runs a self test before it accepts any input. A multiplexer injects two built-in 256-bit patterns into the same health tester, and the block reports one pass or fail verdict. A saturating counter of healthy samples is exposed for debug.

Top module: `entropy_health_widener`

## Requirements
- R1: During and right after reset, the queue is empty (`out_valid`=0, `q_empty`=1, `q_full`=0), `in_ready`=0, `bist_done`=`bist_pass`=`bist_fail`=0 and `hc_count`=0.
- R2: After reset release, the self test feeds two patterns into the tester. The first is alternating bits starting with 0, and must be judged healthy. The second is all ones, and must be judged unhealthy. Both are judged with the fixed default window of 96 to 160 and the run limit, whatever `win_lo`/`win_hi` hold. `bist_done` rises within 600 cycles. `bist_pass` and `bist_fail` are never both 1, and all three flags hold until the next reset.
- R3: `in_ready` is 1 only when `bist_pass` is 1 and the queue is not full. A bit offered while `in_ready` is 0 is not taken.
- R4: The n-th accepted bit of a sample (n = 0..255) appears at `out_data[n]`.
- R5: A sample is healthy only if its ones-count c satisfies `win_lo` <= c <= `win_hi`, both bounds inclusive.
- R6: A sample with a run of more than 34 identical consecutive bits is unhealthy. A run of exactly 34 is allowed. Runs are counted within one sample only.
- R7: Every completed sample is queued, healthy or not, with `out_healthy` = 1 for healthy and 0 for unhealthy.
- R8: The queue holds 4 words in FIFO order. `out_valid` equals not-empty. A word shown while `out_ready` is 0 stays unchanged. `q_full` and `q_empty` reflect the fill state.
- R9: `hc_count` rises by one for each healthy sample queued and saturates at 255.
- R10: A sample completing in the same cycle as a pop both take effect, and the queue occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Raw bit offered |
| in_bit | input | 1 | Raw bit value |
| in_ready | output | 1 | Raw bit accepted this cycle when high with in_valid |
| win_lo | input | 9 | Lowest allowed ones-count (inclusive) |
| win_hi | input | 9 | Highest allowed ones-count (inclusive) |
| out_valid | output | 1 | Queue head word present |
| out_ready | input | 1 | Downstream pops the head word |
| out_data | output | 256 | Head word, first bit in bit 0 |
| out_healthy | output | 1 | Health tag of the head word |
| q_full | output | 1 | Queue holds 4 words |
| q_empty | output | 1 | Queue holds no word |
| bist_done | output | 1 | Self test finished |
| bist_pass | output | 1 | Self test verdicts matched |
| bist_fail | output | 1 | Self test mismatch, held until reset |
| hc_count | output | 8 | Saturating count of healthy samples |

## Verification
The push of a completed sample and the pop of the head word can land on the same clock edge. The bench provokes this by raising `out_ready` in the very cycle that carries the 256th bit of a second sample. At that moment the queue holds one word. The bench judges the result by reading the old head word before the edge, then finding exactly the new word (and nothing else) left afterwards. Sweeps of the ones-count around both window edges, and of run lengths 34 and 35, cover the verdict. A fill-to-full pass checks that offered bits are refused and that queue order is kept.

// File: rtl/ehw_pkg.sv
package ehw_pkg;
  typedef enum logic [1:0] {
    BS_PAT_A,
    BS_PAT_B,
    BS_DONE
  } bist_st_e;
endpackage

// File: rtl/ehw_health_test.sv
module ehw_health_test #(
  parameter int W       = 256,
  parameter int RUN_MAX = 34,
  parameter int CNT_W   = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic [CNT_W-1:0] lo,
  input  logic [CNT_W-1:0] hi,
  output logic             done,
  output logic             ok,
  output logic [W-1:0]     word
);
  localparam int IDX_W = $clog2(W);
  localparam int RUN_W = $clog2(RUN_MAX + 2);

  logic [W-1:0]     sh_q;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] ones_q, ones_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             prev_q, bad_q, bad_d;
  logic             first, last;

  assign first = (idx_q == '0);
  assign last  = (idx_q == IDX_W'(W - 1));

  always_comb begin
    if (first || (bit_in != prev_q))
      run_d = RUN_W'(1);
    else if (run_q == RUN_W'(RUN_MAX + 1))
      run_d = run_q;
    else
      run_d = run_q + RUN_W'(1);
    bad_d  = (first ? 1'b0 : bad_q) | (run_d > RUN_W'(RUN_MAX));
    ones_d = (first ? '0 : ones_q) + CNT_W'(bit_in);
  end

  assign word = {bit_in, sh_q[W-1:1]};
  assign done = bit_valid && last;
  assign ok   = !bad_d && (ones_d >= lo) && (ones_d <= hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      idx_q  <= '0;
      ones_q <= '0;
      run_q  <= '0;
      prev_q <= 1'b0;
      bad_q  <= 1'b0;
    end else if (bit_valid) begin
      sh_q   <= word;
      idx_q  <= last ? '0 : idx_q + IDX_W'(1);
      ones_q <= ones_d;
      run_q  <= run_d;
      prev_q <= bit_in;
      bad_q  <= bad_d;
    end
  end
endmodule

// File: rtl/ehw_bist.sv
module ehw_bist
  import ehw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic t_done,
  input  logic t_ok,
  output logic active,
  output logic t_valid,
  output logic t_bit,
  output logic done,
  output logic pass,
  output logic fail
);
  bist_st_e st_q;
  logic     tog_q, match_a_q, verdict;

  assign active  = (st_q != BS_DONE);
  assign t_valid = active;
  assign t_bit   = (st_q == BS_PAT_A) ? tog_q : 1'b1;
  assign verdict = match_a_q & ~t_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= BS_PAT_A;
      tog_q     <= 1'b0;
      match_a_q <= 1'b0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      case (st_q)
        BS_PAT_A: begin
          tog_q <= ~tog_q;
          if (t_done) begin
            match_a_q <= t_ok;
            st_q      <= BS_PAT_B;
          end
        end
        BS_PAT_B: begin
          if (t_done) begin
            pass <= verdict;
            fail <= ~verdict;
            done <= 1'b1;
            st_q <= BS_DONE;
          end
        end
        default: st_q <= BS_DONE;
      endcase
    end
  end
endmodule

// File: rtl/ehw_queue.sv
module ehw_queue #(
  parameter int DW    = 257,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  output logic [DW-1:0] dout,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= '0;
      else if (do_push && (wp_q == AW'(g)))
        mem[g] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= nxt(wp_q);
      if (do_pop)  rp_q <= nxt(rp_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + CW'(1);
      else if (do_pop && !do_push) cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/entropy_health_widener.sv
module entropy_health_widener #(
  parameter int SAMPLE_W = 256,
  parameter int Q_DEPTH  = 4,
  parameter int RUN_MAX  = 34,
  parameter int DEF_LO   = 96,
  parameter int DEF_HI   = 160,
  parameter int HC_W     = 8,
  parameter int CNT_W    = $clog2(SAMPLE_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_bit,
  output logic                in_ready,
  input  logic [CNT_W-1:0]    win_lo,
  input  logic [CNT_W-1:0]    win_hi,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_healthy,
  output logic                q_full,
  output logic                q_empty,
  output logic                bist_done,
  output logic                bist_pass,
  output logic                bist_fail,
  output logic [HC_W-1:0]     hc_count
);
  localparam int QW = SAMPLE_W + 1;
  localparam logic [HC_W-1:0] HC_MAX = '1;

  logic                b_act, b_valid, b_bit;
  logic                t_valid, t_bit, t_done, t_ok;
  logic [CNT_W-1:0]    t_lo, t_hi;
  logic [SAMPLE_W-1:0] t_word;
  logic                push;
  logic [QW-1:0]       q_out;

  assign in_ready = bist_pass && !q_full;
  assign t_valid  = b_act ? b_valid : (in_valid && in_ready);
  assign t_bit    = b_act ? b_bit : in_bit;
  assign t_lo     = b_act ? CNT_W'(DEF_LO) : win_lo;
  assign t_hi     = b_act ? CNT_W'(DEF_HI) : win_hi;
  assign push     = t_done && !b_act;

  ehw_health_test #(.W(SAMPLE_W), .RUN_MAX(RUN_MAX), .CNT_W(CNT_W)) u_test (
    .clk(clk), .rst_n(rst_n), .bit_valid(t_valid), .bit_in(t_bit),
    .lo(t_lo), .hi(t_hi), .done(t_done), .ok(t_ok), .word(t_word)
  );

  ehw_bist u_bist (
    .clk(clk), .rst_n(rst_n), .t_done(t_done), .t_ok(t_ok),
    .active(b_act), .t_valid(b_valid), .t_bit(b_bit),
    .done(bist_done), .pass(bist_pass), .fail(bist_fail)
  );

  ehw_queue #(.DW(QW), .DEPTH(Q_DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n), .push(push), .din({t_ok, t_word}),
    .pop(out_ready), .dout(q_out), .full(q_full), .empty(q_empty)
  );

  assign out_valid   = !q_empty;
  assign out_data    = q_out[SAMPLE_W-1:0];
  assign out_healthy = q_out[SAMPLE_W];

  always_ff @(posedge clk) begin
    if (!rst_n)
      hc_count <= '0;
    else if (push && t_ok && (hc_count != HC_MAX))
      hc_count <= hc_count + HC_W'(1);
  end
endmodule

// File: rtl/ehw_checker.sv
module ehw_checker #(
  parameter int W    = 256,
  parameter int HC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [W-1:0]    out_data,
  input logic            q_full,
  input logic            q_empty,
  input logic            bist_done,
  input logic            bist_pass,
  input logic            bist_fail,
  input logic [HC_W-1:0] hc_count
);
  localparam logic [HC_W-1:0] HC_MAX = '1;

  a_r3_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !bist_pass) |-> !in_ready);
  a_r3_full_stop: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !in_ready);
  a_r2_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bist_pass && bist_fail));
  a_r2_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    bist_done |=> (bist_done && $stable(bist_pass) && $stable(bist_fail)));
  a_r2_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    (bist_pass || bist_fail) |-> bist_done);
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  a_r8_flags: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> (!q_empty && out_valid));
  a_r9_step: assert property (@(posedge clk) disable iff (!rst_n)
    (hc_count == $past(hc_count)) || (hc_count == HC_W'($past(hc_count) + 1'b1)));
  a_r9_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (hc_count == HC_MAX) |=> (hc_count == HC_MAX));
endmodule

bind entropy_health_widener ehw_checker #(.W(SAMPLE_W), .HC_W(HC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .q_full(q_full), .q_empty(q_empty), .bist_done(bist_done),
  .bist_pass(bist_pass), .bist_fail(bist_fail), .hc_count(hc_count)
);

// File: tb/entropy_health_widener_tb.sv
module entropy_health_widener_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0, in_bit = 1'b0, out_ready = 1'b0;
  logic [8:0]   win_lo = 9'd200, win_hi = 9'd10;
  logic         in_ready, out_valid, out_healthy, q_full, q_empty;
  logic         bist_done, bist_pass, bist_fail;
  logic [255:0] out_data;
  logic [7:0]   hc_count;
  int total = 0, bad = 0, exp_hc = 0;

  always #10 clk = ~clk;

  entropy_health_widener u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit),
    .in_ready(in_ready), .win_lo(win_lo), .win_hi(win_hi),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_healthy(out_healthy), .q_full(q_full), .q_empty(q_empty),
    .bist_done(bist_done), .bist_pass(bist_pass), .bist_fail(bist_fail),
    .hc_count(hc_count)
  );

  task automatic chk(input bit cond, input string tag,
                     input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] kpat(input int k);
    logic [255:0] w;
    for (int i = 0; i < 256; i++) w[i] = (((i + 1) * k) / 256) != ((i * k) / 256);
    return w;
  endfunction

  function automatic logic [255:0] altp();
    logic [255:0] w;
    for (int i = 0; i < 256; i++) w[i] = i[0];
    return w;
  endfunction

  function automatic bit healthy(input logic [255:0] w);
    int ones = 0, run = 0, mx = 0;
    for (int i = 0; i < 256; i++) begin
      ones += int'(w[i]);
      run = (i > 0 && w[i] == w[i-1]) ? run + 1 : 1;
      if (run > mx) mx = run;
    end
    return (ones >= int'(win_lo)) && (ones <= int'(win_hi)) && (mx <= 34);
  endfunction

  task automatic send(input logic [255:0] w);
    for (int i = 0; i < 256; i++) begin
      in_valid = 1'b1;
      in_bit = w[i];
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic pop_chk(input logic [255:0] w, input string tag);
    bit h;
    h = healthy(w);
    chk(out_valid, {tag, " R8 valid"}, 256'(out_valid), 256'd1);
    chk(out_data == w, {tag, " R4 data"}, out_data, w);
    chk(out_healthy == h, {tag, " R5 R6 R7 tag"}, 256'(out_healthy), 256'(h));
    if (h && exp_hc < 255) exp_hc++;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic one(input logic [255:0] w, input string tag);
    send(w);
    pop_chk(w, tag);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [255:0] w, q [4];
    int cyc;
    in_valid = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!out_valid && q_empty && !q_full, "R1 queue", {q_full, q_empty, out_valid}, 3'b010);
    chk(!in_ready, "R1 ready", 256'(in_ready), 0);
    chk({bist_done, bist_pass, bist_fail} == 3'b000, "R1 bist", {bist_done, bist_pass, bist_fail}, 0);
    chk(hc_count == 0, "R1 hc", hc_count, 0);
    rst_n = 1'b1;
    cyc = 0;
    while (!bist_done && cyc < 600) begin
      if (in_ready) chk(1'b0, "R3 ready before pass", 1, 0);
      @(negedge clk);
      cyc++;
    end
    chk(bist_done, "R2 done in time", cyc, 600);
    chk(bist_pass && !bist_fail, "R2 verdict", {bist_pass, bist_fail}, 2'b10);
    chk(q_empty, "R3 bits during test not taken", 256'(q_empty), 1);
    in_valid = 1'b0;
    win_lo = 9'd96;
    win_hi = 9'd160;
    @(negedge clk);

    one(altp(), "alt");
    one('0, "zeros");
    for (int k = 90; k <= 170; k++) one(kpat(k), "sweep R5");
    chk(int'(hc_count) == exp_hc, "R9 count after sweep", hc_count, exp_hc);

    win_lo = 9'd120;
    win_hi = 9'd121;
    for (int k = 119; k <= 122; k++) one(kpat(k), "narrow R5");
    win_lo = 9'd96;
    win_hi = 9'd160;

    for (int L = 33; L <= 36; L++) begin
      w = altp() ^ 256'h1;
      for (int i = 0; i < L; i++) w[i] = 1'b1;
      w[L] = 1'b0;
      one(w, "run R6");
      w = ~altp();
      for (int i = 256 - L; i < 256; i++) w[i] = 1'b0;
      w[255 - L] = 1'b1;
      one(w, "run tail R6");
    end

    w = altp();
    for (int i = 226; i < 256; i++) w[i] = 1'b1;
    one(w, "span a R6");
    w = altp();
    for (int i = 0; i < 30; i++) w[i] = 1'b1;
    one(w, "span b R6");

    // fill to full
    for (int j = 0; j < 4; j++) begin
      q[j] = kpat(100 + 15 * j);
      send(q[j]);
    end
    chk(q_full && !in_ready, "R3 R8 full", {q_full, in_ready}, 2'b10);
    in_valid = 1'b1;
    in_bit = 1'b1;
    for (int j = 0; j < 10; j++) begin
      chk(!in_ready, "R3 refuse when full", 256'(in_ready), 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int j = 0; j < 4; j++) pop_chk(q[j], "fifo R8");
    chk(q_empty && !out_valid, "R8 empty", {q_empty, out_valid}, 2'b10);
    one(kpat(130), "after full R3");

    // same-cycle push and pop
    send(kpat(110));
    w = kpat(140);
    for (int i = 0; i < 256; i++) begin
      in_valid = 1'b1;
      in_bit = w[i];
      if (i == 255) begin
        chk(out_data == kpat(110), "R10 head before", out_data, kpat(110));
        if (healthy(kpat(110)) && exp_hc < 255) exp_hc++;
        out_ready = 1'b1;
      end
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    out_ready = 1'b0;
    pop_chk(w, "R10 new word");
    chk(q_empty, "R10 one left only", 256'(q_empty), 1);

    while (exp_hc < 255) one(altp(), "fill R9");
    chk(hc_count == 8'd255, "R9 reach max", hc_count, 255);
    for (int j = 0; j < 3; j++) one(altp(), "sat R9");
    chk(hc_count == 8'd255, "R9 saturate", hc_count, 255);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule